// File: doc/BRIEF.md
# Descriptor-Driven DMA Transfer Sequencer

This block is a single-master DMA engine. Each channel has a 16-byte descriptor in system memory, placed at `DESC_BASE + 16*channel`. The descriptor word at byte offset 0 is the source end pointer, the word at offset 4 is the destination end pointer, and the word at offset 8 is the control word.

A channel starts when the engine is enabled and that channel's request is pending. The sequencer then works through a fixed series of memory accesses:

1. It fetches the control word.
2. It fetches the source end pointer, then the destination end pointer.
3. It copies the items one word at a time, as a read followed by a write.
4. It waits for the channel's request to drop.
5. It writes the spent control word back and gives a one-cycle done pulse.

Software enables the engine through a small register port. It follows progress through a 4-bit step code in the status register. Clearing the enable lets the current memory access finish and then abandons the transfer.

Top module: `dma_seq`

## Requirements
- R1: After reset the step code is 0, the enable status bit is 0, `mem_req_o` is low and no done output is high.
- R2: The status register (read address 0) returns the channel count minus one in bits 20:16, the step code in bits 7:4 and the enable in bit 0, with all other bits zero. The configuration register (read address 1) always reads zero.
- R3: Writing address 1 with bit 0 set enables the engine and writing it clear disables it; status bit 0 follows. While disabled and idle, a pending request starts no memory access.
- R4: A transfer on channel c first reads byte address `16c+8` (control word), then `16c` (source end), then `16c+4` (destination end).
- R5: The control word holds a mode field in bits 1:0, the source increment enable in bit 2, the destination increment enable in bit 3 and the item count minus one in bits 13:4. With K items remaining after the current one, reads use `src_end - 4K` and writes use `dst_end - 4K` (each pointer is used unchanged when its increment enable is clear). Each write carries the data of the read just before it.
- R6: After the last data write the sequencer holds step code 6 with no memory access until the channel's request is low.
- R7: The write-back goes to `16c+8` and equals the fetched control word with bits 13:4 and 1:0 cleared. Channel c's done output then pulses for exactly one cycle.
- R8: When several requests are pending at idle, the lowest-numbered channel is served first.
- R9: Clearing the enable mid-transfer completes the access in flight and then returns to idle with no control write-back and no done pulse.
- R10: The step code reads 1/2/3 during the control, source and destination fetches, 4 during data reads, 5 during data writes, 6 while waiting for the request to clear, 7 during the write-back and 9 in the cycle of the done pulse; codes above 9 never appear.
- R11: Once `mem_req_o` is raised, the request, address, write flag and write data hold until the cycle in which `mem_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 1 | Register write address (1 = configuration) |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 1 | Register read address (0 status, 1 configuration) |
| reg_rdata_o | output | 32 | Register read data |
| chan_req_i | input | NUM_CH | Per-channel transfer requests |
| chan_done_o | output | NUM_CH | Per-channel one-cycle completion pulses |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory access completes this cycle |

## Verification
The copy sequence is swept over every channel, item counts of one to three, and all four combinations of the two increment enables.

- The channel sweep separates descriptor address generation from channel selection.
- The count sweep exposes off-by-one errors in the remaining-item counter.
- The increment combinations show whether each pointer is offset independently, rather than both following one flag.

Memory latency rotates between zero and two wait cycles, which checks the handshake hold and the step code under stalls.

Three further scenarios complete the set:

- Simultaneous requests on three channels fix the service order.
- A disable issued during a data read shows the abort path differs from normal completion.
- A request held high on a disabled engine shows that nothing starts.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE     = 4'h0,
    ST_RD_CTRL  = 4'h1,
    ST_RD_SRC   = 4'h2,
    ST_RD_DST   = 4'h3,
    ST_RD_DATA  = 4'h4,
    ST_WR_DATA  = 4'h5,
    ST_WAIT_CLR = 4'h6,
    ST_WR_CTRL  = 4'h7,
    ST_SUSPEND  = 4'h8,
    ST_DONE     = 4'h9,
    ST_PSG      = 4'hA
  } dma_state_e;

  localparam int MODE_LSB    = 0;
  localparam int MODE_W      = 2;
  localparam int SRC_INC_BIT = 2;
  localparam int DST_INC_BIT = 3;
  localparam int CNT_LSB     = 4;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs #(
  parameter int NUM_CH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        waddr_i,
  input  logic [31:0] wdata_i,
  input  logic        raddr_i,
  input  logic [3:0]  state_i,
  output logic [31:0] rdata_o,
  output logic        en_o
);
  localparam logic [4:0] CH_M1 = 5'(NUM_CH - 1);

  logic en_q;
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[31:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              en_q <= 1'b0;
    else if (we_i && waddr_i) en_q <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    if (!raddr_i) begin
      rdata_o[20:16] = CH_M1;
      rdata_o[7:4]   = state_i;
      rdata_o[0]     = en_q;
    end
  end

  assign en_o = en_q;

  p_en_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && waddr_i |=> en_o == $past(wdata_i[0]));
  p_en_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && waddr_i) |=> $stable(en_o));
endmodule

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CH_W'(i);
    end
  end

  assign valid_o = |req_i;

  p_lowest_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[idx_o] &&
      ((req_i & ((NUM_CH'(1) << idx_o) - NUM_CH'(1))) == '0));
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int              NUM_CH    = 4,
  parameter int              CH_W      = 2,
  parameter int              AW        = 32,
  parameter int              CNT_W     = 10,
  parameter logic [AW-1:0]   DESC_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              arb_valid_i,
  input  logic [CH_W-1:0]   arb_idx_i,
  input  logic [NUM_CH-1:0] chan_req_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [3:0]        state_o,
  output logic [NUM_CH-1:0] done_o
);
  dma_state_e          state_q;
  logic [CH_W-1:0]     ch_q;
  logic [31:0]         ctrl_q, data_q;
  logic [AW-1:0]       src_q, dst_q;
  logic [CNT_W-1:0]    rem_q;
  logic                xfer;
  logic [AW-1:0]       desc_addr, src_addr, dst_addr, rem_off;
  logic [31:0]         wb_ctrl;

  assign xfer      = mem_req_o && mem_ready_i;
  assign desc_addr = DESC_BASE + (AW'(ch_q) << 4);
  assign rem_off   = AW'(rem_q) << 2;
  assign src_addr  = ctrl_q[SRC_INC_BIT] ? src_q - rem_off : src_q;
  assign dst_addr  = ctrl_q[DST_INC_BIT] ? dst_q - rem_off : dst_q;

  always_comb begin
    wb_ctrl = ctrl_q;
    wb_ctrl[CNT_LSB +: CNT_W]   = '0;
    wb_ctrl[MODE_LSB +: MODE_W] = '0;
  end

  always_comb begin
    mem_req_o  = 1'b1;
    mem_we_o   = 1'b0;
    mem_addr_o = desc_addr + AW'(8);
    case (state_q)
      ST_RD_CTRL: ;
      ST_RD_SRC:  mem_addr_o = desc_addr;
      ST_RD_DST:  mem_addr_o = desc_addr + AW'(4);
      ST_RD_DATA: mem_addr_o = src_addr;
      ST_WR_DATA: begin mem_we_o = 1'b1; mem_addr_o = dst_addr; end
      ST_WR_CTRL: mem_we_o = 1'b1;
      default:    mem_req_o = 1'b0;
    endcase
  end

  assign mem_wdata_o = (state_q == ST_WR_CTRL) ? wb_ctrl : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      ctrl_q  <= '0;
      data_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (en_i && arb_valid_i) begin
          ch_q    <= arb_idx_i;
          state_q <= ST_RD_CTRL;
        end
        ST_RD_CTRL: if (xfer) begin
          if (!en_i) state_q <= ST_IDLE;
          else begin
            ctrl_q  <= mem_rdata_i;
            rem_q   <= mem_rdata_i[CNT_LSB +: CNT_W];
            state_q <= ST_RD_SRC;
          end
        end
        ST_RD_SRC: if (xfer) begin
          if (!en_i) state_q <= ST_IDLE;
          else begin src_q <= AW'(mem_rdata_i); state_q <= ST_RD_DST; end
        end
        ST_RD_DST: if (xfer) begin
          if (!en_i) state_q <= ST_IDLE;
          else begin dst_q <= AW'(mem_rdata_i); state_q <= ST_RD_DATA; end
        end
        ST_RD_DATA: if (xfer) begin
          if (!en_i) state_q <= ST_IDLE;
          else begin data_q <= mem_rdata_i; state_q <= ST_WR_DATA; end
        end
        ST_WR_DATA: if (xfer) begin
          if (!en_i)             state_q <= ST_IDLE;
          else if (rem_q == '0)  state_q <= ST_WAIT_CLR;
          else begin rem_q <= rem_q - 1'b1; state_q <= ST_RD_DATA; end
        end
        ST_WAIT_CLR: begin
          if (!en_i)                  state_q <= ST_IDLE;
          else if (!chan_req_i[ch_q]) state_q <= ST_WR_CTRL;
        end
        ST_WR_CTRL: if (xfer) state_q <= en_i ? ST_DONE : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    done_o = '0;
    if (state_q == ST_DONE) done_o[ch_q] = 1'b1;
  end

  assign state_o = state_q;

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o));
  p_done_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |done_o |=> !(|done_o));
  p_wait_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT_CLR && en_i && chan_req_i[ch_q] |=> state_q == ST_WAIT_CLR);
  p_idle_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && !en_i |=> state_q == ST_IDLE);
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && xfer |=> state_q == ST_IDLE && !(|done_o));
  p_code_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o < 4'hA);
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int            NUM_CH    = 4,
  parameter int            AW        = 32,
  parameter int            CNT_W     = 10,
  parameter logic [AW-1:0] DESC_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_waddr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_raddr_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] chan_req_i,
  output logic [NUM_CH-1:0] chan_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ready_i
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic            en;
  logic            arb_valid;
  logic [CH_W-1:0] arb_idx;
  logic [3:0]      state;

  dma_seq_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .waddr_i (reg_waddr_i),
    .wdata_i (reg_wdata_i),
    .raddr_i (reg_raddr_i),
    .state_i (state),
    .rdata_o (reg_rdata_o),
    .en_o    (en)
  );

  dma_seq_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (chan_req_i),
    .valid_o (arb_valid),
    .idx_o   (arb_idx)
  );

  dma_seq_fsm #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .AW(AW), .CNT_W(CNT_W), .DESC_BASE(DESC_BASE)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .arb_valid_i (arb_valid),
    .arb_idx_i   (arb_idx),
    .chan_req_i  (chan_req_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .done_o      (chan_done_o)
  );
endmodule

// File: tb/dma_seq_tb.sv
module dma_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam logic [31:0] SRC_END = 32'h108;
  localparam logic [31:0] DST_END = 32'h208;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        reg_we_i, reg_waddr_i, reg_raddr_i;
  logic [31:0] reg_wdata_i, reg_rdata_o;
  logic [NCH-1:0] chan_req_i, chan_done_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;

  dma_seq #(.NUM_CH(NCH), .AW(32), .CNT_W(10), .DESC_BASE(32'h0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_waddr_i(reg_waddr_i), .reg_wdata_i(reg_wdata_i),
    .reg_raddr_i(reg_raddr_i), .reg_rdata_o(reg_rdata_o),
    .chan_req_i(chan_req_i), .chan_done_o(chan_done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [31:0] mem [0:255];
  logic        lg_we    [0:63];
  logic [31:0] lg_addr  [0:63];
  logic [31:0] lg_data  [0:63];
  logic [3:0]  lg_state [0:63];
  int lg_n = 0, acc_total = 0, wait_cnt = 0;
  int done_cnt [0:NCH-1];
  int n_chk = 0, n_err = 0;

  // memory model: 0..2 wait cycles, one idle cycle between accesses
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      mem_ready_i = 1'b0;
      wait_cnt = 0;
    end else begin
      for (int c = 0; c < NCH; c++) if (chan_done_o[c]) done_cnt[c]++;
      if (mem_ready_i) begin
        mem_ready_i = 1'b0;
        wait_cnt = 0;
      end else if (mem_req_o) begin
        if (wait_cnt >= acc_total % 3) begin
          mem_ready_i = 1'b1;
          if (mem_we_o) mem[mem_addr_o[9:2]] = mem_wdata_o;
          else          mem_rdata_i = mem[mem_addr_o[9:2]];
          if (lg_n < 64) begin
            lg_we[lg_n]    = mem_we_o;
            lg_addr[lg_n]  = mem_addr_o;
            lg_data[lg_n]  = mem_we_o ? mem_wdata_o : mem_rdata_i;
            lg_state[lg_n] = reg_rdata_o[7:4];
          end
          lg_n++;
          acc_total++;
        end else wait_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  task automatic reg_wr(input logic [31:0] d);
    reg_we_i = 1'b1; reg_waddr_i = 1'b1; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0; reg_waddr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic wait_state(input logic [3:0] s, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (reg_rdata_o[7:4] == s) begin ok = 1'b1; break; end
      tick();
    end
  endtask

  task automatic wait_done(input int c, input int target);
    for (int i = 0; i < 2000; i++) begin
      if (done_cnt[c] >= target) break;
      tick();
    end
  endtask

  task automatic set_desc(input int c, input int n, input bit si, input bit di, input logic [7:0] mark);
    mem[4*c]   = SRC_END;
    mem[4*c+1] = DST_END;
    mem[4*c+2] = {mark, 14'd0, 10'(n-1)} << 4 | {28'd0, di, si, 2'b01};
  endtask

  task automatic do_run(input int c, input int n, input bit si, input bit di, input int run);
    bit ok;
    int d0 [0:NCH-1];
    logic [31:0] ctrl, wb, ra, wa, desc;
    int rem, e;
    for (int k = 0; k < 3; k++) begin
      mem[64+k]  = 32'hC0DE_0000 ^ (run << 8) ^ k;
      mem[128+k] = '0;
    end
    set_desc(c, n, si, di, 8'(run + 8'h40));
    ctrl = mem[4*c+2];
    wb   = ctrl & ~32'h0000_3FF3;
    desc = 32'(16*c);
    for (int k = 0; k < NCH; k++) d0[k] = done_cnt[k];
    lg_n = 0;
    chan_req_i[c] = 1'b1;
    wait_state(4'h6, ok);
    chk(ok, "R6 reach wait-clear", {28'd0, reg_rdata_o[7:4]}, 32'h6);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(reg_rdata_o[7:4] == 4'h6 && !mem_req_o, "R6 hold while request high",
          {27'd0, mem_req_o, reg_rdata_o[7:4]}, 32'h6);
    end
    chan_req_i[c] = 1'b0;
    wait_state(4'h0, ok);
    chk(lg_n == 3 + 2*n + 1, "R4 access count", 32'(lg_n), 32'(3 + 2*n + 1));
    chk(!lg_we[0] && lg_addr[0] == desc + 8 && lg_state[0] == 4'h1, "R4 R10 control fetch", lg_addr[0], desc + 8);
    chk(!lg_we[1] && lg_addr[1] == desc     && lg_state[1] == 4'h2, "R4 R10 source end fetch", lg_addr[1], desc);
    chk(!lg_we[2] && lg_addr[2] == desc + 4 && lg_state[2] == 4'h3, "R4 R10 dest end fetch", lg_addr[2], desc + 4);
    for (int i = 0; i < n; i++) begin
      rem = n - 1 - i;
      ra = si ? SRC_END - 32'(4*rem) : SRC_END;
      wa = di ? DST_END - 32'(4*rem) : DST_END;
      e = 3 + 2*i;
      chk(!lg_we[e] && lg_addr[e] == ra && lg_state[e] == 4'h4, "R5 R10 data read address", lg_addr[e], ra);
      chk(lg_we[e+1] && lg_addr[e+1] == wa && lg_state[e+1] == 4'h5, "R5 R10 data write address", lg_addr[e+1], wa);
      chk(lg_data[e+1] == mem[ra[9:2]], "R5 data copied", lg_data[e+1], mem[ra[9:2]]);
    end
    e = 3 + 2*n;
    chk(lg_we[e] && lg_addr[e] == desc + 8 && lg_state[e] == 4'h7, "R7 R10 write-back address", lg_addr[e], desc + 8);
    chk(mem[4*c+2] == wb, "R7 write-back value", mem[4*c+2], wb);
    for (int k = 0; k < NCH; k++)
      chk(done_cnt[k] == d0[k] + ((k == c) ? 1 : 0), "R7 done pulse count",
          32'(done_cnt[k] - d0[k]), (k == c) ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog all requirements: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit ok, seen;
    int run;
    logic [31:0] ctrl0;
    rst_ni = 1'b0; chan_req_i = '0;
    reg_we_i = 1'b0; reg_waddr_i = 1'b0; reg_wdata_i = '0; reg_raddr_i = 1'b0;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    for (int k = 0; k < NCH; k++) done_cnt[k] = 0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 / R2 reset state and register layout
    chk(reg_rdata_o == 32'h0003_0000, "R1 R2 status after reset", reg_rdata_o, 32'h0003_0000);
    chk(!mem_req_o && chan_done_o == '0, "R1 outputs quiet", {30'd0, mem_req_o, |chan_done_o}, 32'h0);
    reg_raddr_i = 1'b1; #1;
    chk(reg_rdata_o == 32'h0, "R2 configuration reads zero", reg_rdata_o, 32'h0);
    reg_raddr_i = 1'b0; #1;

    // R3 disabled engine ignores requests
    set_desc(0, 1, 1'b1, 1'b1, 8'h11);
    chan_req_i[0] = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin tick(); if (mem_req_o) seen = 1'b1; end
    chk(!seen && reg_rdata_o[7:4] == 4'h0, "R3 no access while disabled", {31'd0, seen}, 32'h0);
    chan_req_i[0] = 1'b0;
    tick();
    reg_wr(32'hFFFF_FFF1);
    chk(reg_rdata_o == 32'h0003_0001, "R2 R3 status after enable", reg_rdata_o, 32'h0003_0001);

    // R4..R7, R10 sweep
    run = 0;
    for (int c = 0; c < NCH; c++)
      for (int n = 1; n <= 3; n++)
        for (int m = 0; m < 4; m++) begin
          do_run(c, n, m[0], m[1], run);
          run++;
        end

    // R8 fixed priority
    reg_wr(32'h0);
    for (int c = 1; c < NCH; c++) set_desc(c, 1, 1'b1, 1'b1, 8'h80);
    lg_n = 0;
    chan_req_i = 4'b1110;
    tick();
    reg_wr(32'h1);
    wait_state(4'h6, ok);
    chk(lg_addr[0] == 32'd24, "R8 lowest channel first", lg_addr[0], 32'd24);
    chan_req_i[1] = 1'b0;
    wait_done(1, done_cnt[1] + 1);
    wait_state(4'h6, ok);
    chk(lg_addr[6] == 32'd40, "R8 next channel second", lg_addr[6], 32'd40);
    chan_req_i[2] = 1'b0;
    wait_done(2, done_cnt[2] + 1);
    wait_state(4'h6, ok);
    chk(lg_addr[12] == 32'd56, "R8 highest channel last", lg_addr[12], 32'd56);
    chan_req_i[3] = 1'b0;
    wait_state(4'h0, ok);

    // R9 disable during a data read
    set_desc(0, 3, 1'b1, 1'b1, 8'h99);
    ctrl0 = mem[2];
    run = done_cnt[0];
    lg_n = 0;
    chan_req_i[0] = 1'b1;
    wait_state(4'h4, ok);
    reg_wr(32'h0);
    wait_state(4'h0, ok);
    chk(ok, "R9 returns to idle", {28'd0, reg_rdata_o[7:4]}, 32'h0);
    seen = 1'b0;
    for (int k = 0; k < lg_n && k < 64; k++) if (lg_state[k] == 4'h4) seen = 1'b1;
    chk(seen, "R9 in-flight read completed", {31'd0, seen}, 32'h1);
    seen = 1'b0;
    for (int k = 0; k < lg_n && k < 64; k++) if (lg_state[k] == 4'h7) seen = 1'b1;
    chk(!seen && mem[2] == ctrl0, "R9 no write-back", mem[2], ctrl0);
    chk(done_cnt[0] == run, "R9 no done pulse", 32'(done_cnt[0] - run), 32'h0);
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin tick(); if (mem_req_o) seen = 1'b1; end
    chk(!seen && reg_rdata_o[0] == 1'b0, "R9 R3 stays idle when disabled", {31'd0, seen}, 32'h0);
    chan_req_i[0] = 1'b0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule